// File: doc/BRIEF.md
# Video Timing Waveform Microcode Sequencer

This block draws the per-pixel waveform of a raster timing generator by running a small stored program. It does not compare fixed horizontal and vertical counters against timing registers. Software fills an instruction store through a write port while the sequencer is idle. A frame-start pulse then launches the program at address zero. The program advances one step per pixel clock. Some instructions drive an 8-bit level, a mux-select bit and a data-enable (DE) strobe. Other instructions hold the bus still for a counted span, loop back to a marked address, jump, park until the next frame start, or stop.

Each program word is 14 bits wide: an opcode in bits 13:10 and an argument in bits 9:0. Two independent loop pairs, each made of a marker and a counter, let a single line pattern serve every active line, with an outer loop around it. The output bus reaches the pins through a fixed pipeline of `LAT` clocks, and programmed skip counts must allow for that delay. The address width `AW` may be at most 6, because bit 6 of a jump argument is a fixed flag.

Top module: `wave_useq`

## Requirements
- R1: Opcode codes, in bits 13:10, are 0 level, 1 level+outer mark, 2 level+inner mark, 3 skip, 4 stop, 5 outer loop, 6 inner loop, 7 jump, 8 park. For the four level-driving opcodes (0, 1, 2, 8), argument bits 7:0 give the level, bit 8 gives the mux-select and bit 9 gives DE.
- R2: After reset, level, DE, mux-select, halted and error all read 0, and the sequencer stays idle until a frame-start pulse.
- R3: A frame-start pulse sampled while the sequencer is idle or halted sets the program counter to 0 and starts execution. While the sequencer is running and not parked, frame-start has no effect.
- R4: A level-driving instruction takes one clock and loads level, mux-select and DE from its argument.
- R5: Skip with argument N leaves the bus unchanged for N+1 clocks in total, then moves to the next address. An argument of 0 takes one clock.
- R6: Opcode 2 records its own address as the inner loop start. Inner loop with argument N runs the region from that mark again N more times, then falls through. An argument of 0 falls through at once. Each inner-loop instruction takes one clock and leaves the bus unchanged.
- R7: Opcodes 1 and 5 form a second loop pair that behaves the same way and counts independently of the inner pair, so the inner pair can be nested inside it.
- R8: Jump loads the program counter from argument bits AW-1:0 and ignores the flag in bit 6. It takes one clock.
- R9: Stop raises halted, ends execution and leaves the bus at its last value.
- R10: Park drives its level and then stays at its address until a frame-start pulse, which moves execution to the next address.
- R11: Opcodes 9 to 15 act as stop and also set an error flag. Only reset clears the error flag.
- R12: A value loaded by an instruction that executes at clock edge k appears on level, DE and mux-select from edge k+LAT onward (LAT = 5).
- R13: The write port stores a 14-bit word at the given address on each clock where the write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | AW | Program store write address |
| prog_data | input | 14 | Program word to write |
| frame_start | input | 1 | Frame-start pulse |
| level_o | output | 8 | Output level, delayed by LAT |
| de_o | output | 1 | Data-enable strobe, delayed by LAT |
| msel_o | output | 1 | Mux-select bit, delayed by LAT |
| halted_o | output | 1 | Program reached a stop |
| err_o | output | 1 | Sticky undefined-opcode flag |

## Verification
A line-shaped program is swept over every skip length from 0 to 5 and every inner repeat count from 0 to 3. The stop time and the DE and mux-select pulse widths are predicted from closed formulas, so an off-by-one in the skip counting can be told apart from one in the loop counting. A nested program sweeps both loop counts, which separates the two counters and their marks. Short directed programs cover the jump flag bit, parking on frame-start, an undefined opcode with a sticky error, and the exact edge at which the LAT-clock pipeline first shows a new level.

// File: rtl/wave_useq_pkg.sv
package wave_useq_pkg;

  localparam int WORD_W = 14;
  localparam int ARG_W  = 10;
  localparam int OP_W   = 4;
  localparam int LVL_W  = 8;

  typedef enum logic [OP_W-1:0] {
    OP_LVL        = 4'd0,
    OP_LVL_MARK_B = 4'd1,
    OP_LVL_MARK_A = 4'd2,
    OP_WAIT       = 4'd3,
    OP_HALT       = 4'd4,
    OP_LOOP_B     = 4'd5,
    OP_LOOP_A     = 4'd6,
    OP_GOTO       = 4'd7,
    OP_PARK       = 4'd8
  } op_e;

  function automatic logic [OP_W-1:0] f_op(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: OP_W];
  endfunction

  function automatic logic [ARG_W-1:0] f_arg(input logic [WORD_W-1:0] w);
    return w[ARG_W-1:0];
  endfunction

  function automatic logic f_drives_level(input logic [OP_W-1:0] op);
    return (op == OP_LVL) || (op == OP_LVL_MARK_A) ||
           (op == OP_LVL_MARK_B) || (op == OP_PARK);
  endfunction

  function automatic logic f_is_undefined(input logic [OP_W-1:0] op);
    return op > OP_PARK;
  endfunction

endpackage

// File: rtl/wave_useq_ram.sv
module wave_useq_ram #(
  parameter int AW = 6,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wave_useq_loop.sv
module wave_useq_loop #(
  parameter int AW = 6,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mark_en,
  input  logic [AW-1:0] mark_pc,
  input  logic          run_en,
  input  logic [CW-1:0] count,
  output logic          take_o,
  output logic [AW-1:0] target_o
);
  logic          busy_q;
  logic [CW-1:0] left_q;
  logic [AW-1:0] mark_q;

  always_comb begin
    take_o = run_en && (busy_q ? (left_q != '0) : (count != '0));
  end
  assign target_o = mark_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      mark_q <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      if (mark_en) mark_q <= mark_pc;
      if (run_en) begin
        if (!busy_q) begin
          if (count != '0) begin
            busy_q <= 1'b1;
            left_q <= count - 1'b1;
          end
        end else if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wave_useq_pipe.sv
module wave_useq_pipe #(
  parameter int W   = 10,
  parameter int LAT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else             stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[LAT-1];
endmodule

// File: rtl/wave_useq.sv
module wave_useq
  import wave_useq_pkg::*;
#(
  parameter int AW  = 6,
  parameter int LAT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [AW-1:0]     prog_addr,
  input  logic [WORD_W-1:0] prog_data,
  input  logic              frame_start,
  output logic [LVL_W-1:0]  level_o,
  output logic              de_o,
  output logic              msel_o,
  output logic              halted_o,
  output logic              err_o
);
  localparam int NLOOP = 2;

  logic [AW-1:0]     pc_q;
  logic              run_q, halt_q, err_q, wait_q;
  logic [ARG_W-1:0]  wcnt_q;
  logic [ARG_W-1:0]  raw_q;
  logic [WORD_W-1:0] instr;
  logic [OP_W-1:0]   op;
  logic [ARG_W-1:0]  arg;
  logic [ARG_W-1:0]  bus_d;

  // named events for the checker
  logic exec_en, restart, set_level;
  logic [NLOOP-1:0] mark_en, loop_run, loop_take;
  logic [AW-1:0]    loop_tgt [NLOOP];

  wave_useq_ram #(.AW(AW), .DW(WORD_W)) u_ram (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(pc_q), .rdata(instr)
  );

  assign op        = f_op(instr);
  assign arg       = f_arg(instr);
  assign exec_en   = run_q & ~wait_q;
  assign restart   = ~run_q & frame_start;
  assign set_level = exec_en & f_drives_level(op);

  // index 0: inner pair (mark A / loop A), index 1: outer pair
  assign mark_en[0]  = exec_en && (op == OP_LVL_MARK_A);
  assign mark_en[1]  = exec_en && (op == OP_LVL_MARK_B);
  assign loop_run[0] = exec_en && (op == OP_LOOP_A);
  assign loop_run[1] = exec_en && (op == OP_LOOP_B);

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    wave_useq_loop #(.AW(AW), .CW(ARG_W)) u_loop (
      .clk(clk), .rst_n(rst_n), .clr(restart),
      .mark_en(mark_en[g]), .mark_pc(pc_q),
      .run_en(loop_run[g]), .count(arg),
      .take_o(loop_take[g]), .target_o(loop_tgt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      run_q  <= 1'b0;
      halt_q <= 1'b0;
      err_q  <= 1'b0;
      wait_q <= 1'b0;
      wcnt_q <= '0;
    end else if (!run_q) begin
      if (frame_start) begin
        run_q  <= 1'b1;
        halt_q <= 1'b0;
        pc_q   <= '0;
        wait_q <= 1'b0;
      end
    end else if (wait_q) begin
      if (wcnt_q <= 1) begin
        wait_q <= 1'b0;
        pc_q   <= pc_q + 1'b1;
      end else begin
        wcnt_q <= wcnt_q - 1'b1;
      end
    end else begin
      case (op)
        OP_LVL, OP_LVL_MARK_A, OP_LVL_MARK_B: pc_q <= pc_q + 1'b1;
        OP_PARK: if (frame_start) pc_q <= pc_q + 1'b1;
        OP_WAIT: begin
          if (arg != '0) begin
            wait_q <= 1'b1;
            wcnt_q <= arg;
          end else begin
            pc_q <= pc_q + 1'b1;
          end
        end
        OP_LOOP_A: pc_q <= loop_take[0] ? loop_tgt[0] : pc_q + 1'b1;
        OP_LOOP_B: pc_q <= loop_take[1] ? loop_tgt[1] : pc_q + 1'b1;
        OP_GOTO:   pc_q <= arg[AW-1:0];
        OP_HALT: begin
          run_q  <= 1'b0;
          halt_q <= 1'b1;
        end
        default: begin
          run_q  <= 1'b0;
          halt_q <= 1'b1;
          err_q  <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         raw_q <= '0;
    else if (set_level) raw_q <= arg;
  end

  assign bus_d = raw_q;

  logic [ARG_W-1:0] bus_q;
  wave_useq_pipe #(.W(ARG_W), .LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .d(bus_d), .q(bus_q)
  );

  assign level_o  = bus_q[LVL_W-1:0];
  assign msel_o   = bus_q[8];
  assign de_o     = bus_q[9];
  assign halted_o = halt_q;
  assign err_o    = err_q;
endmodule

// File: rtl/wave_useq_chk.sv
module wave_useq_chk
  import wave_useq_pkg::*;
#(
  parameter int AW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             exec_en,
  input logic [OP_W-1:0]  op,
  input logic [ARG_W-1:0] arg,
  input logic [AW-1:0]    pc_q,
  input logic             run_q,
  input logic             halt_q,
  input logic             err_q,
  input logic             wait_q,
  input logic [ARG_W-1:0] wcnt_q,
  input logic [ARG_W-1:0] raw_q
);
  p_stop_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == OP_HALT) |=> halt_q && !run_q);

  p_bad_op_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op > OP_PARK) |=> err_q && halt_q);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_skip_holds_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q && (wcnt_q > 1) |=> wait_q && $stable(pc_q));

  p_skip_holds_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |=> $stable(raw_q));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && frame_start |=> run_q && (pc_q == '0) && !halt_q);

  p_goto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == OP_GOTO) |=> pc_q == $past(arg[AW-1:0]));

  p_park_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == OP_PARK) && !frame_start |=> $stable(pc_q) && run_q);
endmodule

bind wave_useq wave_useq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .exec_en(exec_en), .op(op), .arg(arg), .pc_q(pc_q),
  .run_q(run_q), .halt_q(halt_q), .err_q(err_q),
  .wait_q(wait_q), .wcnt_q(wcnt_q), .raw_q(raw_q)
);

// File: tb/wave_useq_tb.sv
module wave_useq_tb;
  localparam int AW  = 6;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [13:0] prog_data = '0;
  logic frame_start = 1'b0;
  logic [7:0] level_o;
  logic de_o, msel_o, halted_o, err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wave_useq #(.AW(AW), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .frame_start(frame_start), .level_o(level_o),
    .de_o(de_o), .msel_o(msel_o), .halted_o(halted_o), .err_o(err_o)
  );

  // encodings restated from R1
  function automatic logic [13:0] w_lvl(input int opc, input int de, input int ms, input int lv);
    return {opc[3:0], de[0], ms[0], lv[7:0]};
  endfunction
  function automatic logic [13:0] w_cnt(input int opc, input int n);
    return {opc[3:0], n[9:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [13:0] d);
    @(negedge clk);
    prog_we = 1'b1;
    prog_addr = a[AW-1:0];
    prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // runs one frame; returns edge index of first halted and pulse counts
  task automatic run_frame(input int max_k, input int inject_k,
                           output int halt_k, output int de_n, output int ms_n);
    halt_k = 0; de_n = 0; ms_n = 0;
    pulse_start();
    for (int k = 1; k <= max_k; k++) begin
      if (k == inject_k) frame_start = 1'b1;
      if (k == inject_k + 1) frame_start = 1'b0;
      @(negedge clk);
      if (de_o) de_n++;
      if (msel_o) ms_n++;
      if (halted_o && halt_k == 0) halt_k = k;
      if (halt_k != 0 && k >= halt_k + LAT + 3) break;
    end
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hk, dn, mn;
    do_reset();
    // R2 reset state
    chk(level_o == 0 && !de_o && !msel_o, "R2 bus after reset", level_o, 0);
    chk(!halted_o && !err_o, "R2 flags after reset", {halted_o, err_o}, 0);
    repeat (10) @(negedge clk);
    chk(!halted_o && level_o == 0, "R2 idle without start", level_o, 0);

    // R4 R5 R6 R1 R3: line program sweep
    for (int n = 0; n <= 5; n++) begin
      for (int r = 0; r <= 3; r++) begin
        do_reset();
        wr(0, w_lvl(2, 0, 0, 8'h10));
        wr(1, w_lvl(0, 1, 1, 8'hA5));
        wr(2, w_cnt(3, n));
        wr(3, w_lvl(0, 0, 0, 8'h10));
        wr(4, w_cnt(6, r));
        wr(5, w_cnt(4, 0));
        run_frame(400, 2, hk, dn, mn);
        chk(hk == (n + 5) * (r + 1) + 1, "R5 R6 R3 stop edge", hk, (n + 5) * (r + 1) + 1);
        chk(dn == (n + 2) * (r + 1), "R4 R5 R6 DE width", dn, (n + 2) * (r + 1));
        chk(mn == (n + 2) * (r + 1), "R1 mux field", mn, (n + 2) * (r + 1));
        chk(level_o == 8'h10 && !err_o, "R9 bus held after stop", level_o, 8'h10);
      end
    end

    // R7 nested loops
    for (int a = 0; a <= 2; a++) begin
      for (int b = 0; b <= 2; b++) begin
        do_reset();
        wr(0, w_lvl(1, 0, 0, 8'h01));
        wr(1, w_lvl(2, 1, 0, 8'h02));
        wr(2, w_cnt(6, a));
        wr(3, w_cnt(5, b));
        wr(4, w_lvl(0, 0, 0, 8'h00));
        wr(5, w_cnt(4, 0));
        run_frame(400, 0, hk, dn, mn);
        chk(hk == (b + 1) * (2 * a + 4) + 2, "R7 nested stop edge", hk, (b + 1) * (2 * a + 4) + 2);
        chk(dn == (b + 1) * (2 * a + 3), "R7 nested DE count", dn, (b + 1) * (2 * a + 3));
      end
    end

    // R8 jump with flag bit
    do_reset();
    wr(0, w_lvl(0, 1, 1, 8'h33));
    wr(1, w_cnt(7, 'h43));
    wr(2, w_lvl(0, 0, 0, 8'hEE));
    wr(3, w_lvl(0, 0, 0, 8'h44));
    wr(4, w_cnt(4, 0));
    begin
      bit saw_ee = 1'b0;
      pulse_start();
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (level_o == 8'hEE) saw_ee = 1'b1;
        if (k == 4) chk(halted_o, "R8 jump stop edge", halted_o, 1);
      end
      chk(!saw_ee, "R8 skipped word never driven", saw_ee, 0);
      chk(level_o == 8'h44, "R8 target level", level_o, 8'h44);
    end

    // R10 park, R13 program rewrite
    do_reset();
    wr(0, w_lvl(0, 0, 0, 8'h11));
    wr(1, w_lvl(8, 1, 0, 8'h55));
    wr(2, w_lvl(0, 0, 0, 8'h66));
    wr(3, w_cnt(4, 0));
    pulse_start();
    repeat (30) @(negedge clk);
    chk(!halted_o && level_o == 8'h55 && de_o, "R10 parked", level_o, 8'h55);
    pulse_start();
    repeat (12) @(negedge clk);
    chk(halted_o && level_o == 8'h66, "R10 resumed after start", level_o, 8'h66);
    wr(2, w_lvl(0, 0, 0, 8'h77));
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    repeat (12) @(negedge clk);
    chk(level_o == 8'h77, "R13 rewritten word", level_o, 8'h77);

    // R12 latency
    do_reset();
    wr(0, w_lvl(0, 0, 0, 8'h7C));
    wr(1, w_cnt(3, 20));
    wr(2, w_cnt(4, 0));
    pulse_start();
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == LAT) chk(level_o == 0, "R12 not yet visible", level_o, 0);
      if (k == LAT + 1) chk(level_o == 8'h7C, "R12 visible at edge", level_o, 8'h7C);
    end

    // R11 undefined opcode
    do_reset();
    wr(0, w_lvl(0, 1, 0, 8'h21));
    wr(1, w_cnt(12, 0));
    pulse_start();
    repeat (10) @(negedge clk);
    chk(halted_o && err_o, "R11 undefined halts with error", {halted_o, err_o}, 3);
    wr(1, w_cnt(4, 0));
    pulse_start();
    repeat (10) @(negedge clk);
    chk(err_o && halted_o, "R11 error sticky over restart", err_o, 1);
    do_reset();
    chk(!err_o, "R11 reset clears error", err_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule